// File: doc/BRIEF.md
# Bus-Programmed Channel Enable Switch Controller

This block is the control side of a bus-steered channel switch. It is a slave on a two-wire serial bus (I2C). The bus lines are open-drain, and each is modelled as a plain input. The block pulls SDA low through a single enable output. A small state machine follows START and STOP conditions and checks the slave address against a fixed upper nibble plus three strap pins. Write data bytes are collected into a pending byte. On a read, the block shifts out the active selection.

The eight bits of the active selection drive eight channel enables directly, and any mix of channels may be on at once. A written byte does not take effect when it arrives. It is applied only when the bus next shows a STOP, so the downstream segments are joined only while every line is idle-high. An active-low reset clears the selection, the pending byte and the bus state machine, and it holds the block inert for as long as it stays low.

State machine. The states are IDLE, ADDR (shifting in the address byte), ADDR_ACK, WDATA, WACK, RDATA, RACK and WAIT (ignoring the bus). The transitions are:
- Any state goes to ADDR on START and to IDLE on STOP.
- ADDR goes to ADDR_ACK on an address hit, and to WAIT on a miss. Either happens on the SCL fall after the eighth bit.
- ADDR_ACK goes to RDATA if the R/W bit is 1, or to WDATA if it is 0, on the next SCL fall.
- WDATA goes to WACK after eight bits.
- WACK goes back to WDATA on the next SCL fall.
- RDATA goes to RACK on the SCL fall that ends its eighth bit.
- RACK goes to RDATA if the master acknowledged, or to WAIT if it did not, on the next SCL fall.

Top module: `chsel_i2c_top`

## Requirements
- R1: While rst_n is low, chan_en is 0x00 and sda_oe is 0, taking effect without waiting for a clock edge. Any pending byte is discarded, so the next STOP leaves chan_en at 0x00.
- R2: The block acknowledges an address byte (sda_oe=1 during the ninth SCL pulse) only when its top seven bits equal binary 1110 followed by addr_pins[2], addr_pins[1], addr_pins[0]. Bit 0 is R/W, with 1 for a read and 0 for a write. On a mismatch, the block drives no acknowledge for the rest of the transaction and chan_en does not change.
- R3: After an acknowledged write address, every data byte (MSB first) is acknowledged. Bit n of the written byte enables chan_en[n]. For example, 0x4C enables channels 6, 3 and 2.
- R4: chan_en changes only on a STOP condition, which applies the pending byte. Before the STOP it keeps its previous value.
- R5: When several data bytes are written in one transaction, the value applied at STOP is the last of them.
- R6: A read returns the current chan_en value, MSB first. The value is repeated for each byte the master acknowledges. After the master's NACK, sda_oe stays 0 until the next START or STOP.
- R7: A START arriving in the middle of a byte abandons that byte and returns to address reception. A data byte completed earlier in the same transaction is still applied at the next STOP.
- R8: sda_oe changes only while SCL is low, except when a START, STOP or reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_pins | input | 3 | Strap pins forming the low three address bits |
| sda_oe | output | 1 | 1 pulls SDA low |
| chan_en | output | 8 | Active channel enables, bit n for channel n |

## Verification
Two functions can act in the same stretch of the bus:
- the acknowledge drive on SDA;
- the asynchronous reset.

The bench provokes this by pulling rst_n low while the block holds SDA low for a write-data acknowledge, with a different selection already active. Inside the same clock period it judges that sda_oe has dropped and chan_en reads 0x00. The following STOP must then leave chan_en at zero, because the interrupted byte must not survive the reset.

A second overlap is a START that lands mid-byte while an earlier byte is still pending. The bench checks that the earlier byte, and not the fragment, is applied at the later STOP.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } bus_state_t;

    localparam int unsigned BUS_BYTE_W = 8;

endpackage

// File: rtl/chsel_bus_sync.sv
module chsel_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/chsel_i2c_fsm.sv
module chsel_i2c_fsm
    import chsel_pkg::*;
#(
    parameter int unsigned    PIN_W   = 3,
    parameter logic [3:0]     ADDR_HI = 4'b1110
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_s,
    input  logic                  sda_s,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    input  logic [PIN_W-1:0]      addr_pins,
    output logic                  sda_oe,
    output logic [BUS_BYTE_W-1:0] chan_en
);

    localparam int unsigned DW    = BUS_BYTE_W;
    localparam int unsigned CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DW);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DW - 1);

    bus_state_t          state, state_nxt;
    logic [DW-1:0]       shreg;
    logic [DW-1:0]       pending;
    logic                pend_valid;
    logic [DW-1:0]       chan_q;
    logic [CNT_W-1:0]    cnt;
    logic                mack;
    logic                addr_hit;

    assign addr_hit = (shreg[DW-1:1] == {ADDR_HI, addr_pins});
    assign chan_en  = chan_q;

    // next-state decision
    always_comb begin
        state_nxt = state;
        if (start_det) begin
            state_nxt = ST_ADDR;
        end else if (stop_det) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: ;
                ST_ADDR:     if (scl_fall && cnt == CNT_FULL)
                                 state_nxt = addr_hit ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK: if (scl_fall)
                                 state_nxt = shreg[0] ? ST_RDATA : ST_WDATA;
                ST_WDATA:    if (scl_fall && cnt == CNT_FULL) state_nxt = ST_WACK;
                ST_WACK:     if (scl_fall) state_nxt = ST_WDATA;
                ST_RDATA:    if (scl_fall && cnt == CNT_LAST) state_nxt = ST_RACK;
                ST_RACK:     if (scl_fall) state_nxt = mack ? ST_RDATA : ST_WAIT;
                default:     state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // datapath: shifter, bit counter, pending and committed selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            pending    <= '0;
            pend_valid <= 1'b0;
            chan_q     <= '0;
            cnt        <= '0;
            mack       <= 1'b0;
        end else if (start_det) begin
            cnt <= '0;
        end else if (stop_det) begin
            cnt <= '0;
            if (pend_valid) begin
                chan_q     <= pending;
                pend_valid <= 1'b0;
            end
        end else begin
            unique case (state)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise && cnt != CNT_FULL) begin
                        shreg <= {shreg[DW-2:0], sda_s};
                        cnt   <= cnt + CNT_W'(1);
                    end
                    if (state == ST_WDATA && scl_fall && cnt == CNT_FULL) begin
                        pending    <= shreg;
                        pend_valid <= 1'b1;
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    cnt <= '0;
                    if (shreg[0]) shreg <= chan_q;
                end
                ST_WACK: if (scl_fall) cnt <= '0;
                ST_RDATA: if (scl_fall && cnt != CNT_LAST) begin
                    shreg <= {shreg[DW-2:0], 1'b0};
                    cnt   <= cnt + CNT_W'(1);
                end
                ST_RACK: begin
                    if (scl_rise) mack <= ~sda_s;
                    if (scl_fall && mack) begin
                        shreg <= chan_q;
                        cnt   <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WACK: sda_oe = 1'b1;
            ST_RDATA:             sda_oe = ~shreg[DW-1];
            default:              sda_oe = 1'b0;
        endcase
    end

    // R8: pull-down stable while SCL stays high and no bus condition occurred
    a_r8_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R4: selection moves only after a STOP
    a_r4_chan_hold_without_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stop_det) |-> $stable(chan_en));

    // R7: START always restarts address reception from bit zero
    a_r7_start_restarts_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && cnt == '0));

    // R3: a write acknowledge always has a byte waiting to be applied
    a_r3_wack_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WACK) |-> pend_valid);

    // R6: line released while the master answers a read byte
    a_r6_rack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK) |-> !sda_oe);

endmodule

// File: rtl/chsel_i2c_top.sv
module chsel_i2c_top
    import chsel_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PIN_W       = 3,
    parameter logic [3:0]  ADDR_HI     = 4'b1110
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [PIN_W-1:0]      addr_pins,
    output logic                  sda_oe,
    output logic [BUS_BYTE_W-1:0] chan_en
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    chsel_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    chsel_i2c_fsm #(.PIN_W(PIN_W), .ADDR_HI(ADDR_HI)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_pins (addr_pins),
        .sda_oe    (sda_oe),
        .chan_en   (chan_en)
    );

endmodule

// File: tb/chsel_i2c_top_tb_top.sv
module chsel_i2c_top_tb_top;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] addr_pins = 3'b101;
    logic       sda_oe;
    logic [7:0] chan_en;
    logic       sda_line;

    int checks = 0;
    int fails = 0;
    int r8_viol = 0;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;

    logic [7:0] exp_chan = 8'h00;
    logic [7:0] exp_pend = 8'h00;
    logic       exp_pv = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    chsel_i2c_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .addr_pins (addr_pins),
        .sda_oe    (sda_oe),
        .chan_en   (chan_en)
    );

    // R8 monitor: pull-down must not move while SCL is held high
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev && sda_m == sda_line && sda_oe != oe_prev) r8_viol++;
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    function automatic logic [7:0] addr_byte(input logic [2:0] pins, input logic rw);
        return {4'b1110, pins, rw};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
        sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold(); hold();
        if (exp_pv) begin exp_chan = exp_pend; exp_pv = 1'b0; end
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; hold(); scl_m = 1'b1; hold(); hold(); scl_m = 1'b0; hold();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); b = sda_line; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_bit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack_it);
        logic b;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin get_bit(b); d = {d[6:0], b}; end
        send_bit(~ack_it);
    endtask

    task automatic write_txn(input logic [2:0] pins, input logic [7:0] d0, input int nb);
        logic ack;
        logic hit;
        logic [7:0] d;
        hit = (pins == addr_pins);
        bus_start();
        send_byte(addr_byte(pins, 1'b0), ack);
        chk("R2 addr ack", {7'd0, ack}, {7'd0, hit});
        for (int i = 0; i < nb; i++) begin
            d = (i == nb - 1) ? d0 : 8'($urandom);
            send_byte(d, ack);
            chk(hit ? "R3 data ack" : "R2 ignored data", {7'd0, ack}, {7'd0, hit});
            if (hit) begin exp_pend = d; exp_pv = 1'b1; end
        end
        chk("R4 hold before stop", chan_en, exp_chan);
        bus_stop();
        chk(nb > 1 ? "R5 last byte kept" : "R3 applied", chan_en, exp_chan);
    endtask

    task automatic read_txn(input logic [2:0] pins, input int nb);
        logic ack;
        logic hit;
        logic [7:0] d;
        hit = (pins == addr_pins);
        bus_start();
        send_byte(addr_byte(pins, 1'b1), ack);
        chk("R2 addr ack", {7'd0, ack}, {7'd0, hit});
        if (hit) begin
            for (int i = 0; i < nb; i++) begin
                recv_byte(d, i < nb - 1);
                chk("R6 read data", d, exp_chan);
            end
            hold();
            chk("R6 released after nack", {7'd0, sda_oe}, 8'h00);
        end
        bus_stop();
        chk("R2 chan unchanged by read", chan_en, exp_chan);
    endtask

    initial begin : main
        logic ack;
        logic [7:0] d;
        logic [2:0] pins;
        void'($urandom(32'd4242));
        #3 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset chan", chan_en, 8'h00);
        chk("R1 reset oe", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        hold();

        // directed: 0x4C selects channels 6,3,2
        write_txn(3'b101, 8'h4C, 1);
        chk("R3 channel map", {5'd0, chan_en[6], chan_en[3], chan_en[2]}, 8'h07);
        read_txn(3'b101, 2);

        // new strap pins: old address ignored
        addr_pins = 3'b010;
        write_txn(3'b101, 8'hFF, 1);
        write_txn(3'b010, 8'h81, 3);

        // START inside a byte after a completed byte (R7)
        bus_start();
        send_byte(addr_byte(3'b010, 1'b0), ack);
        send_byte(8'h3C, ack);
        exp_pend = 8'h3C; exp_pv = 1'b1;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte(addr_byte(3'b111, 1'b0), ack);
        chk("R7 foreign addr after restart", {7'd0, ack}, 8'h00);
        chk("R7 not applied before stop", chan_en, 8'h81);
        bus_stop();
        chk("R7 earlier byte applied", chan_en, 8'h3C);

        // abort mid-address then read after repeated start
        bus_start();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        bus_start();
        send_byte(addr_byte(3'b010, 1'b1), ack);
        chk("R7 addr after abort", {7'd0, ack}, 8'h01);
        recv_byte(d, 1'b0);
        chk("R7 read after abort", d, 8'h3C);
        bus_stop();

        // reset during a write acknowledge (R1)
        bus_start();
        send_byte(addr_byte(3'b010, 1'b0), ack);
        for (int i = 7; i >= 0; i--) send_bit(1'b1);
        sda_m = 1'b1; hold();
        chk("R3 ack held", {7'd0, sda_oe}, 8'h01);
        rst_n = 1'b0;
        #1;
        chk("R1 async oe", {7'd0, sda_oe}, 8'h00);
        chk("R1 async chan", chan_en, 8'h00);
        exp_chan = 8'h00; exp_pv = 1'b0;
        hold();
        rst_n = 1'b1;
        scl_m = 1'b0; hold();
        bus_stop();
        chk("R1 pending dropped", chan_en, 8'h00);

        // constrained random mix
        for (int t = 0; t < 30; t++) begin
            pins = ($urandom % 4 == 0) ? 3'($urandom) : addr_pins;
            if ($urandom % 2 == 0) write_txn(pins, 8'($urandom), 1 + int'($urandom % 3));
            else                   read_txn(pins, 1 + int'($urandom % 3));
        end

        chk("R8 oe stable while scl high", 8'(r8_viol), 8'h00);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule